// File: doc/BRIEF.md
# Byte file-register ALU with flags

This block executes the byte-wide register-file instructions of a small 8-bit controller core. Each instruction names one file location. The block forms that location's address from the current bank select and the low opcode bits. It reads the location, combines it with the working register W, and returns the result either to W or to the same file location. It also produces the updated carry, digit-carry and zero flags, plus a skip request for the count-and-skip instructions.

The surrounding core owns instruction fetch, the program counter and the register file itself. It presents an instruction with `op_valid`, answers the combinational read address with the file byte on `mem_rdata` in the same cycle, and picks up the registered results one clock later. The core acts on whichever of the W strobe and the file write strobe is raised, takes `status_out` as the new flag set, and discards the next fetched instruction when `skip_req` is high.

Top module: `file_reg_alu`

## Requirements
- R1: The read address `mem_raddr` equals `{bank_sel, opcode[6:0]}` (bank select shifted left by 7, ORed with opcode bits 6:0) in the same cycle, and a file write goes to that same address.
- R2: Opcode bit 7 selects the destination. With bit 7 at 0 the result goes to W (`w_we`=1, `mem_we`=0). With bit 7 at 1 it goes to the file location (`mem_we`=1, `w_we`=0). Both strobes are never high together.
- R3: Add (opcode bits 11:8 = 7) sets C (status bit 0) when the 8-bit sum overflows. It sets DC (status bit 1) when the two low nibbles sum above 15, and sets Z (status bit 2) when the result is zero.
- R4: Subtract (bits 11:8 = 2) produces f − W. C is 1 when no borrow occurs (f ≥ W), DC is 1 when there is no borrow out of the low nibble, and Z follows the result.
- R5: Rotate right (bits 11:8 = 0xC) shifts C into bit 7 and bit 0 into C. Rotate left (0xD) shifts C into bit 0 and bit 7 into C. Both leave Z and DC unchanged.
- R6: Nibble swap (0xE) exchanges bits 7:4 and 3:0 of f and leaves all three flags unchanged.
- R7: Decrement-and-skip (0xB) and increment-and-skip (0xF) write f∓1. They raise `skip_req` exactly when that result is zero, and they leave all flags unchanged.
- R8: OR (4), AND (5), XOR (6), move (8), complement (9), increment (0xA) and decrement (3) update Z alone. Move-W-to-file (0x0 with bit 7 set) writes W to the file location and changes no flag.
- R9: Clear (0x1) writes zero to W (bit 7 = 0) or to the file location (bit 7 = 1) and forces Z to 1, leaving C and DC unchanged.
- R10: An opcode whose bits 13:12 are not 00, or whose bits 11:7 are all zero, is ignored. It causes no write, no skip, leaves `w_new` equal to `w_in`, and passes `status_in` through unchanged.
- R11: Results appear one clock after `op_valid` with `res_valid` high. After reset, and in any cycle that follows one without `op_valid`, the block raises no strobe, and `status_out` holds its last value (zero after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| opcode | input | 14 | Instruction word |
| w_in | input | 8 | Current W |
| bank_sel | input | 6 | Current bank select |
| status_in | input | 3 | Current flags {Z, DC, C} |
| mem_raddr | output | 13 | File read address |
| mem_rdata | input | 8 | File byte at `mem_raddr`, same cycle |
| res_valid | output | 1 | Results below belong to last cycle's instruction |
| mem_we | output | 1 | File write strobe |
| mem_waddr | output | 13 | File write address |
| mem_wdata | output | 8 | File write data |
| w_we | output | 1 | W write strobe |
| w_new | output | 8 | New W value |
| status_out | output | 3 | New flags {Z, DC, C} |
| skip_req | output | 1 | Skip the next instruction |

## Verification
The hardest cases to reach are the ones where a single bit decides a flag. Examples are a subtract whose operands are equal in the low nibble only, an add that carries out of bit 3 but not bit 7, and a count-and-skip whose operand is exactly one step from zero. Random operands almost never land there. The stimulus therefore runs a directed list of these boundary pairs first. The random phase then draws file and W values from a pool biased toward 0x00, 0x01, 0x0F, 0x10 and 0xFF, and randomises the incoming carry so the rotate and flag-preservation cases see both polarities.

// File: rtl/file_reg_alu_pkg.sv
package file_reg_alu_pkg;
   localparam int ST_W    = 3;
   localparam int FLAG_C  = 0;
   localparam int FLAG_DC = 1;
   localparam int FLAG_Z  = 2;

   typedef enum logic [4:0] {
      OP_NONE, OP_MOVWF, OP_CLR, OP_SUB, OP_DEC, OP_IOR, OP_AND, OP_XOR,
      OP_ADD, OP_MOV, OP_COM, OP_INC, OP_DECSZ, OP_ROR, OP_ROL, OP_SWAP,
      OP_INCSZ
   } fra_op_e;
endpackage

// File: rtl/file_reg_alu_decode.sv
module file_reg_alu_decode
   import file_reg_alu_pkg::*;
#(
   parameter int OP_W    = 14,
   parameter int BANK_W  = 6,
   parameter int FADDR_W = 7
) (
   input  logic [OP_W-1:0]           opcode,
   input  logic [BANK_W-1:0]         bank_sel,
   output fra_op_e                   op,
   output logic                      to_file,
   output logic [BANK_W+FADDR_W-1:0] addr
);
   localparam int GRP_LO = FADDR_W + 1;
   localparam int CLS_LO = FADDR_W + 5;

   generate
      if (OP_W != FADDR_W + 7) begin : g_bad_op_w
         $error("OP_W must equal FADDR_W + 7");
      end
   endgenerate

   logic [3:0]           grp;
   logic [OP_W-CLS_LO-1:0] cls;
   logic                 dbit;

   assign grp  = opcode[GRP_LO+3:GRP_LO];
   assign cls  = opcode[OP_W-1:CLS_LO];
   assign dbit = opcode[FADDR_W];
   assign addr = {bank_sel, opcode[FADDR_W-1:0]};

   always_comb begin
      op = OP_NONE;
      if (cls == '0) begin
         case (grp)
            4'h0: op = dbit ? OP_MOVWF : OP_NONE;
            4'h1: op = OP_CLR;
            4'h2: op = OP_SUB;
            4'h3: op = OP_DEC;
            4'h4: op = OP_IOR;
            4'h5: op = OP_AND;
            4'h6: op = OP_XOR;
            4'h7: op = OP_ADD;
            4'h8: op = OP_MOV;
            4'h9: op = OP_COM;
            4'hA: op = OP_INC;
            4'hB: op = OP_DECSZ;
            4'hC: op = OP_ROR;
            4'hD: op = OP_ROL;
            4'hE: op = OP_SWAP;
            default: op = OP_INCSZ;
         endcase
      end
      to_file = (op != OP_NONE) && dbit;
   end
endmodule

// File: rtl/file_reg_alu_core.sv
module file_reg_alu_core
   import file_reg_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  fra_op_e           op,
   input  logic [DATA_W-1:0] f_val,
   input  logic [DATA_W-1:0] w_val,
   input  logic [ST_W-1:0]   st_in,
   output logic [DATA_W-1:0] result,
   output logic [ST_W-1:0]   st_out,
   output logic              skip
);
   localparam int NIB_W = DATA_W / 2;
   localparam logic [NIB_W:0] NIB_MAX = {1'b0, {NIB_W{1'b1}}};

   generate
      if (DATA_W < 4 || (DATA_W % 2) != 0) begin : g_bad_data_w
         $error("DATA_W must be even and at least 4");
      end
   endgenerate

   logic [DATA_W:0] wide;
   logic            upd_z;

   always_comb begin
      result = f_val;
      st_out = st_in;
      skip   = 1'b0;
      upd_z  = 1'b0;
      wide   = '0;
      case (op)
         OP_MOVWF: result = w_val;
         OP_CLR: begin
            result = '0;
            upd_z  = 1'b1;
         end
         OP_SUB: begin
            wide   = {1'b0, f_val} + {1'b0, ~w_val} + (DATA_W+1)'(1);
            result = wide[DATA_W-1:0];
            st_out[FLAG_C]  = wide[DATA_W];
            st_out[FLAG_DC] = ({1'b0, f_val[NIB_W-1:0]} + {1'b0, ~w_val[NIB_W-1:0]}
                               + (NIB_W+1)'(1)) > NIB_MAX;
            upd_z  = 1'b1;
         end
         OP_ADD: begin
            wide   = {1'b0, f_val} + {1'b0, w_val};
            result = wide[DATA_W-1:0];
            st_out[FLAG_C]  = wide[DATA_W];
            st_out[FLAG_DC] = ({1'b0, f_val[NIB_W-1:0]} + {1'b0, w_val[NIB_W-1:0]}) > NIB_MAX;
            upd_z  = 1'b1;
         end
         OP_DEC: begin result = f_val - DATA_W'(1); upd_z = 1'b1; end
         OP_INC: begin result = f_val + DATA_W'(1); upd_z = 1'b1; end
         OP_IOR: begin result = f_val | w_val; upd_z = 1'b1; end
         OP_AND: begin result = f_val & w_val; upd_z = 1'b1; end
         OP_XOR: begin result = f_val ^ w_val; upd_z = 1'b1; end
         OP_MOV: upd_z = 1'b1;
         OP_COM: begin result = ~f_val; upd_z = 1'b1; end
         OP_DECSZ: begin
            result = f_val - DATA_W'(1);
            skip   = (result == '0);
         end
         OP_INCSZ: begin
            result = f_val + DATA_W'(1);
            skip   = (result == '0);
         end
         OP_ROR: begin
            result = {st_in[FLAG_C], f_val[DATA_W-1:1]};
            st_out[FLAG_C] = f_val[0];
         end
         OP_ROL: begin
            result = {f_val[DATA_W-2:0], st_in[FLAG_C]};
            st_out[FLAG_C] = f_val[DATA_W-1];
         end
         OP_SWAP: result = {f_val[NIB_W-1:0], f_val[DATA_W-1:NIB_W]};
         default: ;
      endcase
      if (upd_z) st_out[FLAG_Z] = (result == '0);
   end

   always_comb begin
      if (op == OP_CLR) begin
         AST_CLR_Z: assert (st_out[FLAG_Z] && st_out[1:0] == st_in[1:0]); // R9
      end
   end
endmodule

// File: rtl/file_reg_alu.sv
module file_reg_alu
   import file_reg_alu_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int BANK_W  = 6,
   parameter int FADDR_W = 7,
   parameter int OP_W    = 14,
   parameter bit REG_OUT = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      op_valid,
   input  logic [OP_W-1:0]           opcode,
   input  logic [DATA_W-1:0]         w_in,
   input  logic [BANK_W-1:0]         bank_sel,
   input  logic [2:0]                status_in,
   output logic [BANK_W+FADDR_W-1:0] mem_raddr,
   input  logic [DATA_W-1:0]         mem_rdata,
   output logic                      res_valid,
   output logic                      mem_we,
   output logic [BANK_W+FADDR_W-1:0] mem_waddr,
   output logic [DATA_W-1:0]         mem_wdata,
   output logic                      w_we,
   output logic [DATA_W-1:0]         w_new,
   output logic [2:0]                status_out,
   output logic                      skip_req
);
   localparam int ADDR_W = BANK_W + FADDR_W;

   fra_op_e           op;
   logic              to_file;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] result;
   logic [ST_W-1:0]   st_nxt;
   logic              skip_nxt;
   logic              wr_file, wr_w;
   logic [DATA_W-1:0] w_nxt;

   file_reg_alu_decode #(.OP_W(OP_W), .BANK_W(BANK_W), .FADDR_W(FADDR_W)) u_dec (
      .opcode(opcode), .bank_sel(bank_sel), .op(op), .to_file(to_file), .addr(addr)
   );

   file_reg_alu_core #(.DATA_W(DATA_W)) u_core (
      .op(op), .f_val(mem_rdata), .w_val(w_in), .st_in(status_in),
      .result(result), .st_out(st_nxt), .skip(skip_nxt)
   );

   assign mem_raddr = addr;
   assign wr_file   = op_valid && (op != OP_NONE) && to_file;
   assign wr_w      = op_valid && (op != OP_NONE) && !to_file;
   assign w_nxt     = wr_w ? result : w_in;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_valid  <= 1'b0;
               mem_we     <= 1'b0;
               w_we       <= 1'b0;
               skip_req   <= 1'b0;
               mem_waddr  <= '0;
               mem_wdata  <= '0;
               w_new      <= '0;
               status_out <= '0;
            end else begin
               res_valid <= op_valid;
               mem_we    <= wr_file;
               w_we      <= wr_w;
               skip_req  <= op_valid && skip_nxt;
               if (op_valid) begin
                  mem_waddr  <= addr;
                  mem_wdata  <= result;
                  w_new      <= w_nxt;
                  status_out <= st_nxt;
               end
            end
         end

         AST_ONE_DEST: assert property (@(posedge clk) disable iff (!rst_n)
            !(mem_we && w_we)); // R2
         AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            !res_valid |-> (!mem_we && !w_we && !skip_req)); // R11
         AST_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            skip_req |-> (mem_we ? (mem_wdata == '0) : (w_new == '0))); // R7
         AST_SWAP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == OP_SWAP) |=> (status_out == $past(status_in))); // R6
         AST_ROT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && (op == OP_ROR || op == OP_ROL))
            |=> (status_out[2:1] == $past(status_in[2:1]))); // R5
         AST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && op == OP_NONE)
            |=> (!mem_we && !w_we && !skip_req && status_out == $past(status_in))); // R10
      end else begin : g_comb
         assign res_valid  = op_valid;
         assign mem_we     = wr_file;
         assign w_we       = wr_w;
         assign skip_req   = op_valid && skip_nxt;
         assign mem_waddr  = addr;
         assign mem_wdata  = result;
         assign w_new      = w_nxt;
         assign status_out = st_nxt;
      end
   endgenerate
endmodule

// File: tb/file_reg_alu_tb.sv
module file_reg_alu_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [13:0] opcode = '0;
   logic [7:0]  w_in = '0;
   logic [5:0]  bank_sel = '0;
   logic [2:0]  status_in = '0;
   logic [12:0] mem_raddr;
   logic [7:0]  mem_rdata = '0;
   logic        res_valid, mem_we, w_we, skip_req;
   logic [12:0] mem_waddr;
   logic [7:0]  mem_wdata, w_new;
   logic [2:0]  status_out;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   int p_valid = 0, p_mwe = 0, p_wwe = 0, p_addr = 0, p_res = 0;
   int p_wnew = 0, p_st = 0, p_skip = 0;
   string p_tag = "R11";

   always #5 clk = ~clk;

   file_reg_alu u_dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .w_in(w_in),
      .bank_sel(bank_sel), .status_in(status_in), .mem_raddr(mem_raddr),
      .mem_rdata(mem_rdata), .res_valid(res_valid), .mem_we(mem_we),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .w_we(w_we), .w_new(w_new),
      .status_out(status_out), .skip_req(skip_req)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic compare();
      chk("R11", "res_valid", int'(res_valid), p_valid);
      chk("R2", "mem_we", int'(mem_we), p_mwe);
      chk("R2", "w_we", int'(w_we), p_wwe);
      chk(p_tag, "status", int'(status_out), p_st);
      chk(p_tag, "skip", int'(skip_req), p_skip);
      if (p_mwe != 0) begin
         chk("R1", "waddr", int'(mem_waddr), p_addr);
         chk(p_tag, "wdata", int'(mem_wdata), p_res);
      end
      if (p_valid != 0) chk(p_tag, "w_new", int'(w_new), p_wnew);
   endtask

   task automatic apply(input int v, input int opc, input int w, input int bank,
                        input int st, input int f);
      int cls, grp, d, c, res, nst, zu, sk, live;
      op_valid  = v[0];
      opcode    = opc[13:0];
      w_in      = w[7:0];
      bank_sel  = bank[5:0];
      status_in = st[2:0];
      mem_rdata = f[7:0];
      cls = (opc >> 12) & 3; grp = (opc >> 8) & 15; d = (opc >> 7) & 1;
      c = st & 1; nst = st; zu = 0; sk = 0; res = f;
      live = (cls == 0) && !(grp == 0 && d == 0);
      p_tag = "R8";
      if (live) begin
         case (grp)
            0: res = w;
            1: begin res = 0; zu = 1; p_tag = "R9"; end
            2: begin
               res = (f - w) & 255; zu = 1; p_tag = "R4";
               nst = (nst & ~3) | (f >= w ? 1 : 0) | ((f & 15) >= (w & 15) ? 2 : 0);
            end
            3: begin res = (f + 255) & 255; zu = 1; end
            4: begin res = f | w; zu = 1; end
            5: begin res = f & w; zu = 1; end
            6: begin res = f ^ w; zu = 1; end
            7: begin
               res = (f + w) & 255; zu = 1; p_tag = "R3";
               nst = (nst & ~3) | (f + w > 255 ? 1 : 0) | ((f & 15) + (w & 15) > 15 ? 2 : 0);
            end
            8: zu = 1;
            9: begin res = (~f) & 255; zu = 1; end
            10: begin res = (f + 1) & 255; zu = 1; end
            11: begin res = (f + 255) & 255; sk = (res == 0); p_tag = "R7"; end
            12: begin res = (c << 7) | (f >> 1); nst = (nst & ~1) | (f & 1); p_tag = "R5"; end
            13: begin res = ((f << 1) & 255) | c; nst = (nst & ~1) | (f >> 7); p_tag = "R5"; end
            14: begin res = ((f & 15) << 4) | (f >> 4); p_tag = "R6"; end
            default: begin res = (f + 1) & 255; sk = (res == 0); p_tag = "R7"; end
         endcase
         if (zu) nst = (nst & 3) | (res == 0 ? 4 : 0);
      end else begin
         p_tag = "R10";
      end
      p_valid = v;
      p_mwe   = v && live && d;
      p_wwe   = v && live && !d;
      p_addr  = (bank << 7) | (opc & 127);
      p_res   = res;
      p_skip  = v && sk;
      if (v) begin
         p_wnew = p_wwe ? res : w;
         p_st   = nst;
      end
      if (!v) p_tag = "R11";
      #1;
      chk("R1", "raddr", int'(mem_raddr), (bank << 7) | (opc & 127));
   endtask

   task automatic step(input int v, input int opc, input int w, input int bank,
                       input int st, input int f);
      @(negedge clk);
      compare();
      apply(v, opc, w, bank, st, f);
   endtask

   function automatic int pick_byte(input int r);
      case (r % 7)
         0: return 8'h00;
         1: return 8'h01;
         2: return 8'h0F;
         3: return 8'h10;
         4: return 8'hFF;
         default: return $urandom_range(0, 255);
      endcase
   endfunction

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk("R11", "reset valid", int'(res_valid), 0);
      chk("R11", "reset status", int'(status_out), 0);
      chk("R11", "reset strobes", int'(mem_we | w_we | skip_req), 0);
      rst_n = 1'b1;
      // R4: subtract corners
      step(1, 14'h0285, 8'h00, 3, 0, 8'h00);
      step(1, 14'h0285, 8'h01, 3, 7, 8'h00);
      step(1, 14'h0205, 8'h13, 1, 0, 8'h23);
      step(1, 14'h0205, 8'h05, 1, 0, 8'h14);
      // R3: add corners
      step(1, 14'h0711, 8'h01, 0, 0, 8'h0F);
      step(1, 14'h0791, 8'h01, 0, 0, 8'hFF);
      step(1, 14'h0711, 8'h80, 0, 2, 8'h80);
      // R7: skip on zero, flags kept
      step(1, 14'h0B80, 0, 63, 5, 8'h01);
      step(1, 14'h0B00, 0, 63, 2, 8'h02);
      step(1, 14'h0F80, 0, 63, 4, 8'hFF);
      // R5 / R6
      step(1, 14'h0C20, 0, 2, 7, 8'h01);
      step(1, 14'h0DA0, 0, 2, 0, 8'h80);
      step(1, 14'h0E20, 0, 2, 3, 8'hA5);
      // R9: clear
      step(1, 14'h0100, 8'h55, 0, 0, 8'h33);
      step(1, 14'h01FF, 8'h55, 63, 3, 8'h33);
      // R10: ignored codes
      step(1, 14'h0000, 8'h12, 0, 5, 8'h34);
      step(1, 14'h0064, 8'h12, 0, 6, 8'h34);
      step(1, 14'h2785, 8'h12, 0, 1, 8'h34);
      // R11: idle cycle
      step(0, 14'h0785, 8'h12, 0, 1, 8'h34);
      // R8: move W to file
      step(1, 14'h00AA, 8'h00, 5, 0, 8'h77);
      for (int i = 0; i < 4000; i++) begin
         int v, opc;
         v = ($urandom_range(0, 99) < 85) ? 1 : 0;
         opc = ($urandom_range(0, 19) == 0) ? $urandom_range(0, 16383)
                                            : $urandom_range(0, 4095);
         step(v, opc, pick_byte($urandom), $urandom_range(0, 63),
              $urandom_range(0, 7), pick_byte($urandom));
      end
      step(0, 0, 0, 0, 0, 0);
      @(negedge clk);
      compare();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule